// File: doc/BRIEF.md
# Strobed Serial Register-Access Slave

This block is the device-side logic of a small control register bank. A host reaches it through four general-purpose pins: an active-low clear, a strobe, a data-in line and a data-out line. The block samples those pins with its own clock. It finds strobe rising edges and steps through each access one bit per edge. An access starts with an 8-bit command, which carries a direction flag and a register address. A 16-bit data phase follows. In a write the host shifts a value in. In a read the block shifts the addressed value out.

The bank holds two read-only identification words and eight read/write control words. There are two function-enable words, three GPIO-enable words and three GPIO-direction words. The control words drive the block's outputs, where pin-mux and indicator logic elsewhere on the chip read them. A build parameter selects a smaller variant with fewer control words. Any access outside the implemented set is filtered out.

Top module: `strobe_reg_slave`

## Requirements
- R1: A low level on clearN, once synchronized, aborts any access in progress and returns the block to the first command bit. A write cut short by clear changes no register, and the next complete access behaves normally.
- R2: The command is 8 bits, most significant bit first, each taken on a strobe rising edge. Bit 7 is the direction flag (1 = read) and bits 6:0 are the register address.
- R3: A write carries 16 data bits, most significant bit first, each taken on a strobe rise. The value is committed on the local clock cycle after the 16th data bit is taken, and only if all 16 bits arrived with no clear in between.
- R4: In a read, dataOut shows bit 15 of the addressed word within 3 local clock cycles of the first data-phase strobe rise. Each later rise presents the next lower bit, and dataOut is stable between these events.
- R5: Once the 16th data bit has been taken, further strobe rises are ignored until the next clear. They neither shift the command nor change any register.
- R6: Address 0x10 reads the PLATFORM_ID parameter, whose bits 7:0 are 0x01. Address 0x11 reads the FIRMWARE_ID parameter, whose bits 11:8 are 0. Writes to either address are discarded.
- R7: Addresses 0x20 to 0x21 are function-enable words, 0x30 to 0x32 are GPIO-enable words and 0x40 to 0x42 are GPIO-direction words. Each is read/write. Address base+k drives bits [16k+15:16k] of funcEnOut, gpioEnOut or gpioDirOut respectively.
- R8: Reads of any other address return 0x0000, and writes to any other address are discarded.
- R9: With SMALL_MAP=1, only 0x20, 0x30 to 0x31 and 0x40 to 0x41 exist. The top slice of each output stays 0, and the missing addresses behave as in R8.
- R10: After reset every control word is 0 and dataOut is low. dataOut is also driven low while clear is active and for the whole of a write access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, at least 4x the strobe rate |
| rstN | input | 1 | Active-low asynchronous reset |
| clearN | input | 1 | Host clear pin, active low, frames each access |
| strobe | input | 1 | Host bit strobe; rising edges advance the access |
| dataIn | input | 1 | Host-to-device serial data |
| dataOut | output | 1 | Device-to-host serial read data |
| funcEnOut | output | 32 | Function-enable words, 0x20 in bits 15:0 |
| gpioEnOut | output | 48 | GPIO-enable words, 0x30 in bits 15:0 |
| gpioDirOut | output | 48 | GPIO-direction words, 0x40 in bits 15:0 |

## Verification
The hardest cases to reach are the states where the strobe keeps toggling with no clear to frame it. One is a write cut off halfway through its data phase. The other is a stream of rising edges after an access has already completed. The stimulus aborts a write after eight data bits and then checks that the target word is unchanged before a full rewrite. It also replays a whole command and sixteen data bits with no clear after a finished write, then reads the target back to prove nothing moved. A second instance built with the small map shares the same pins, so each write also exercises the filtering of the missing words.

// File: rtl/strobe_reg_pkg.sv
package strobe_reg_pkg;

  localparam int MAX_FUNC = 2;
  localparam int MAX_GPIO = 3;

  localparam int PLAT_ADDR     = 'h10;
  localparam int FW_ADDR       = 'h11;
  localparam int FUNC_BASE     = 'h20;
  localparam int GPIO_EN_BASE  = 'h30;
  localparam int GPIO_DIR_BASE = 'h40;

  // strobes issued by the control half to the datapath half
  typedef struct packed {
    logic clearCmd;   // synchronized clear active
    logic cmdBit;     // take one command bit
    logic dataFirst;  // first data-phase rise
    logic dataBit;    // later data-phase rise
    logic commit;     // cycle after the last data bit
    logic bitIn;      // synchronized data-in value
  } ctl_strobes_t;

endpackage

// File: rtl/strobe_reg_ctrl.sv
module strobe_reg_ctrl
  import strobe_reg_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearN,
  input  logic         strobe,
  input  logic         dataIn,
  output ctl_strobes_t ctl
);

  localparam int CMD_W = ADDR_W + 1;
  localparam int TOTAL = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic [SYNC_STAGES-1:0] clrSync, stbSync, dinSync;
  logic                   stbPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic                   commitQ;
  logic                   rise, clrAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrSync <= '1;
      stbSync <= '0;
      dinSync <= '0;
      stbPrev <= 1'b0;
    end else begin
      clrSync <= {clrSync[SYNC_STAGES-2:0], clearN};
      stbSync <= {stbSync[SYNC_STAGES-2:0], strobe};
      dinSync <= {dinSync[SYNC_STAGES-2:0], dataIn};
      stbPrev <= stbSync[SYNC_STAGES-1];
    end
  end

  assign rise   = stbSync[SYNC_STAGES-1] & ~stbPrev;
  assign clrAct = ~clrSync[SYNC_STAGES-1];

  // bit counter: 0..CMD_W-1 command, CMD_W..TOTAL-1 data, TOTAL = done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      commitQ <= 1'b0;
    end else if (clrAct) begin
      bitCnt  <= '0;
      commitQ <= 1'b0;
    end else begin
      commitQ <= 1'b0;
      if (rise && bitCnt < CNT_W'(TOTAL)) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(TOTAL - 1)) commitQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.clearCmd  = clrAct;
    ctl.bitIn     = dinSync[SYNC_STAGES-1];
    ctl.commit    = commitQ;
    ctl.cmdBit    = rise & ~clrAct & (bitCnt < CNT_W'(CMD_W));
    ctl.dataFirst = rise & ~clrAct & (bitCnt == CNT_W'(CMD_W));
    ctl.dataBit   = rise & ~clrAct & (bitCnt > CNT_W'(CMD_W)) &
                    (bitCnt < CNT_W'(TOTAL));
  end

endmodule

// File: rtl/strobe_reg_dpath.sv
module strobe_reg_dpath
  import strobe_reg_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 16,
  parameter bit                SMALL_MAP   = 1'b0,
  parameter logic [DATA_W-1:0] PLATFORM_ID = 16'h0001,
  parameter logic [DATA_W-1:0] FIRMWARE_ID = 16'h0000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_strobes_t               ctl,
  output logic                       dataOut,
  output logic [MAX_FUNC*DATA_W-1:0] funcEnOut,
  output logic [MAX_GPIO*DATA_W-1:0] gpioEnOut,
  output logic [MAX_GPIO*DATA_W-1:0] gpioDirOut
);

  localparam int CMD_W    = ADDR_W + 1;
  localparam int NUM_FUNC = SMALL_MAP ? 1 : MAX_FUNC;
  localparam int NUM_GPIO = SMALL_MAP ? 2 : MAX_GPIO;

  logic [CMD_W-1:0]  cmdReg;
  logic [DATA_W-1:0] wrSh, rdSh, rdWord;
  logic              dataOutQ;
  logic              isRead, wrEn;
  logic [ADDR_W-1:0] addr;

  assign isRead  = cmdReg[CMD_W-1];
  assign addr    = cmdReg[ADDR_W-1:0];
  assign wrEn    = ctl.commit & ~isRead;
  assign dataOut = dataOutQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg   <= '0;
      wrSh     <= '0;
      rdSh     <= '0;
      dataOutQ <= 1'b0;
    end else if (ctl.clearCmd) begin
      cmdReg   <= '0;
      rdSh     <= '0;
      dataOutQ <= 1'b0;
    end else begin
      if (ctl.cmdBit) cmdReg <= {cmdReg[CMD_W-2:0], ctl.bitIn};
      if (ctl.dataFirst || ctl.dataBit) wrSh <= {wrSh[DATA_W-2:0], ctl.bitIn};
      if (ctl.dataFirst) begin
        if (isRead) {dataOutQ, rdSh} <= {rdWord, 1'b0};
        else        {dataOutQ, rdSh} <= '0;
      end else if (ctl.dataBit) begin
        {dataOutQ, rdSh} <= {rdSh, 1'b0};
      end
    end
  end

  for (genvar g = 0; g < MAX_FUNC; g++) begin : g_func
    if (g < NUM_FUNC) begin : g_impl
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (wrEn && addr == ADDR_W'(FUNC_BASE + g)) q <= wrSh;
      end
      assign funcEnOut[g*DATA_W +: DATA_W] = q;
    end else begin : g_absent
      assign funcEnOut[g*DATA_W +: DATA_W] = '0;
    end
  end

  for (genvar g = 0; g < MAX_GPIO; g++) begin : g_gpio
    if (g < NUM_GPIO) begin : g_impl
      logic [DATA_W-1:0] enQ, dirQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enQ  <= '0;
          dirQ <= '0;
        end else if (wrEn) begin
          if (addr == ADDR_W'(GPIO_EN_BASE + g))  enQ  <= wrSh;
          if (addr == ADDR_W'(GPIO_DIR_BASE + g)) dirQ <= wrSh;
        end
      end
      assign gpioEnOut[g*DATA_W +: DATA_W]  = enQ;
      assign gpioDirOut[g*DATA_W +: DATA_W] = dirQ;
    end else begin : g_absent
      assign gpioEnOut[g*DATA_W +: DATA_W]  = '0;
      assign gpioDirOut[g*DATA_W +: DATA_W] = '0;
    end
  end

  // read mux: absent slices are tied to zero, so they read back as 0
  always_comb begin
    rdWord = '0;
    if (addr == ADDR_W'(PLAT_ADDR)) rdWord = PLATFORM_ID;
    if (addr == ADDR_W'(FW_ADDR))   rdWord = FIRMWARE_ID;
    for (int i = 0; i < MAX_FUNC; i++)
      if (addr == ADDR_W'(FUNC_BASE + i)) rdWord = funcEnOut[i*DATA_W +: DATA_W];
    for (int i = 0; i < MAX_GPIO; i++) begin
      if (addr == ADDR_W'(GPIO_EN_BASE + i))  rdWord = gpioEnOut[i*DATA_W +: DATA_W];
      if (addr == ADDR_W'(GPIO_DIR_BASE + i)) rdWord = gpioDirOut[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import strobe_reg_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter bit                SMALL_MAP   = 1'b0,
  parameter logic [DATA_W-1:0] PLATFORM_ID = 16'h5A01,
  parameter logic [DATA_W-1:0] FIRMWARE_ID = 16'h7035
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearN,
  input  logic                       strobe,
  input  logic                       dataIn,
  output logic                       dataOut,
  output logic [MAX_FUNC*DATA_W-1:0] funcEnOut,
  output logic [MAX_GPIO*DATA_W-1:0] gpioEnOut,
  output logic [MAX_GPIO*DATA_W-1:0] gpioDirOut
);

  ctl_strobes_t ctlBus;

  strobe_reg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clearN(clearN), .strobe(strobe),
    .dataIn(dataIn), .ctl(ctlBus)
  );

  strobe_reg_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SMALL_MAP(SMALL_MAP),
    .PLATFORM_ID(PLATFORM_ID), .FIRMWARE_ID(FIRMWARE_ID)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .dataOut(dataOut),
    .funcEnOut(funcEnOut), .gpioEnOut(gpioEnOut), .gpioDirOut(gpioDirOut)
  );

endmodule

// File: rtl/strobe_reg_chk.sv
module strobe_reg_chk
  import strobe_reg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit SMALL_MAP = 1'b0
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       clearCmd,
  input logic                       cmdBit,
  input logic                       dataFirst,
  input logic                       dataBit,
  input logic                       commit,
  input logic                       dataOut,
  input logic [MAX_FUNC*DATA_W-1:0] funcEnOut,
  input logic [MAX_GPIO*DATA_W-1:0] gpioEnOut,
  input logic [MAX_GPIO*DATA_W-1:0] gpioDirOut
);

  AST_CLEAR_DOUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> !dataOut); // R10

  AST_REGS_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> ($stable(funcEnOut) && $stable(gpioEnOut) && $stable(gpioDirOut))); // R3

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdBit, dataFirst, dataBit, commit})); // R2

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(dataFirst || dataBit || clearCmd) |=> $stable(dataOut)); // R4

  if (SMALL_MAP) begin : g_small
    AST_SMALL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      funcEnOut[MAX_FUNC*DATA_W-1 -: DATA_W] == '0 &&
      gpioEnOut[MAX_GPIO*DATA_W-1 -: DATA_W] == '0 &&
      gpioDirOut[MAX_GPIO*DATA_W-1 -: DATA_W] == '0); // R9
  end

endmodule

bind strobe_reg_slave strobe_reg_chk #(.DATA_W(DATA_W), .SMALL_MAP(SMALL_MAP)) u_chk (
  .clk(clk), .rstN(rstN),
  .clearCmd(ctlBus.clearCmd), .cmdBit(ctlBus.cmdBit),
  .dataFirst(ctlBus.dataFirst), .dataBit(ctlBus.dataBit), .commit(ctlBus.commit),
  .dataOut(dataOut), .funcEnOut(funcEnOut), .gpioEnOut(gpioEnOut),
  .gpioDirOut(gpioDirOut)
);

// File: tb/test_strobe_reg_slave.sv
module test_strobe_reg_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [15:0] PLAT = 16'h5A01;
  localparam logic [15:0] FW   = 16'h7035;

  logic clk = 1'b0, rstN = 1'b0, hClr = 1'b1, hStb = 1'b0, hDin = 1'b0;
  logic dOut, dOutS;
  logic [31:0] fEn, fEnS;
  logic [47:0] gEn, gDir, gEnS, gDirS;

  strobe_reg_slave #(.PLATFORM_ID(PLAT), .FIRMWARE_ID(FW)) i_strobe_reg_slave (
    .clk(clk), .rstN(rstN), .clearN(hClr), .strobe(hStb), .dataIn(hDin),
    .dataOut(dOut), .funcEnOut(fEn), .gpioEnOut(gEn), .gpioDirOut(gDir));

  strobe_reg_slave #(.SMALL_MAP(1'b1), .PLATFORM_ID(PLAT), .FIRMWARE_ID(FW))
    i_strobe_reg_slave_small (
    .clk(clk), .rstN(rstN), .clearN(hClr), .strobe(hStb), .dataIn(hDin),
    .dataOut(dOutS), .funcEnOut(fEnS), .gpioEnOut(gEnS), .gpioDirOut(gDirS));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] expQ[$], gotQ[$];
  string tagQ[$];

  task automatic chk(string tag, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClear();
    hClr = 1'b0; waitClk(4);
    hClr = 1'b1; waitClk(4);
  endtask

  task automatic cmdBits(bit rd, logic [6:0] a, int nBits);
    logic [7:0] c = {rd, a};
    for (int i = 7; i > 7 - nBits; i--) begin
      hStb = 1'b0; hDin = c[i]; waitClk(HALF);
      hStb = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic dataBits(logic [15:0] d, int nBits, output int highSeen);
    highSeen = 0;
    for (int i = 15; i > 15 - nBits; i--) begin
      hStb = 1'b0; hDin = d[i]; waitClk(HALF);
      if (dOut) highSeen++;
      hStb = 1'b1; waitClk(HALF);
    end
  endtask

  task automatic writeReg(logic [6:0] a, logic [15:0] d, output int highSeen);
    pulseClear();
    cmdBits(1'b0, a, 8);
    dataBits(d, 16, highSeen);
    hStb = 1'b0; waitClk(HALF);
    hStb = 1'b1; waitClk(HALF);   // trailing rise left high
  endtask

  task automatic readReg(logic [6:0] a, output logic [15:0] w, output logic [15:0] ws);
    pulseClear();
    cmdBits(1'b1, a, 8);
    hStb = 1'b0; waitClk(HALF);
    w = '0; ws = '0;
    for (int i = 15; i >= 0; i--) begin
      hStb = 1'b1; waitClk(HALF);
      hStb = 1'b0; waitClk(HALF);
      w[i] = dOut; ws[i] = dOutS;
    end
    hStb = 1'b1; waitClk(HALF);
  endtask

  // driver side of the scoreboard
  task automatic readCheck(logic [6:0] a, logic [15:0] exp, string tag,
                           output logic [15:0] smallWord);
    logic [15:0] w;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    readReg(a, w, smallWord);
    gotQ.push_back(w);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0)
        chk(tagQ.pop_front(), {32'h0, gotQ.pop_front()}, {32'h0, expQ.pop_front()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hs;
    logic [15:0] sw;
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    // R10 reset state
    chk("R10 reset dataOut", {47'h0, dOut}, 48'h0);
    chk("R10 reset funcEn", {16'h0, fEn}, 48'h0);
    chk("R10 reset gpioEn/dir", gEn | gDir, 48'h0);

    // R6 identification words, R2 command decode, R4 read order
    readCheck(7'h10, PLAT, "R6 R2 R4 platform id read", sw);
    readCheck(7'h11, FW, "R6 firmware id read", sw);
    chk("R6 platform low byte", {40'h0, PLAT[7:0]}, 48'h01);
    chk("R6 firmware major zero", {44'h0, FW[11:8]}, 48'h0);

    // R7 R3 writes to every control word; R10 dataOut low during writes
    writeReg(7'h20, 16'hA5C3, hs);
    chk("R10 dataOut low in write", hs, 0);
    writeReg(7'h21, 16'h1234, hs);
    writeReg(7'h30, 16'h0F0F, hs);
    writeReg(7'h31, 16'h8001, hs);
    writeReg(7'h32, 16'hFFFF, hs);
    writeReg(7'h40, 16'h00FF, hs);
    writeReg(7'h41, 16'hC0DE, hs);
    writeReg(7'h42, 16'h7E57, hs);
    waitClk(2);
    chk("R7 R3 funcEnOut", {16'h0, fEn}, {16'h0, 16'h1234, 16'hA5C3});
    chk("R7 R3 gpioEnOut", gEn, {16'hFFFF, 16'h8001, 16'h0F0F});
    chk("R7 R3 gpioDirOut", gDir, {16'h7E57, 16'hC0DE, 16'h00FF});
    readCheck(7'h21, 16'h1234, "R7 readback 0x21", sw);
    readCheck(7'h42, 16'h7E57, "R7 readback 0x42", sw);

    // R9 small variant on shared pins
    chk("R9 small funcEnOut", {16'h0, fEnS}, {32'h0, 16'hA5C3});
    chk("R9 small gpioEnOut", gEnS, {16'h0, 16'h8001, 16'h0F0F});
    chk("R9 small gpioDirOut", gDirS, {16'h0, 16'hC0DE, 16'h00FF});
    readCheck(7'h21, 16'h1234, "R9 main 0x21", sw);
    chk("R9 small 0x21 reads zero", {32'h0, sw}, 48'h0);
    readCheck(7'h41, 16'hC0DE, "R9 main 0x41", sw);
    chk("R9 small 0x41 reads value", {32'h0, sw}, {32'h0, 16'hC0DE});

    // R6 write to ID discarded, R8 unmapped
    writeReg(7'h10, 16'hFFFF, hs);
    writeReg(7'h11, 16'h0F00, hs);
    readCheck(7'h10, PLAT, "R6 platform id after write", sw);
    readCheck(7'h11, FW, "R6 firmware id after write", sw);
    writeReg(7'h55, 16'hBEEF, hs);
    waitClk(2);
    chk("R8 outputs unchanged by unmapped write", gEn ^ gDir,
        {16'hFFFF, 16'h8001, 16'h0F0F} ^ {16'h7E57, 16'hC0DE, 16'h00FF});
    readCheck(7'h55, 16'h0000, "R8 unmapped read", sw);
    readCheck(7'h33, 16'h0000, "R8 gap read 0x33", sw);

    // R1 abort mid data phase and mid command
    pulseClear();
    cmdBits(1'b0, 7'h31, 8);
    dataBits(16'h0000, 8, hs);
    pulseClear();
    waitClk(4);
    chk("R1 aborted write no effect", gEn, {16'hFFFF, 16'h8001, 16'h0F0F});
    pulseClear();
    cmdBits(1'b0, 7'h40, 3);
    writeReg(7'h31, 16'h4242, hs);
    waitClk(2);
    chk("R1 access after abort", gEn, {16'hFFFF, 16'h4242, 16'h0F0F});

    // R5 rises after a finished access are ignored
    writeReg(7'h20, 16'h6666, hs);
    cmdBits(1'b0, 7'h20, 8);
    dataBits(16'h0000, 16, hs);
    waitClk(4);
    chk("R5 extra rises ignored", {16'h0, fEn}, {16'h0, 16'h1234, 16'h6666});
    readCheck(7'h20, 16'h6666, "R5 readback after extra rises", sw);

    // R10 dataOut low during clear
    hClr = 1'b0; waitClk(4);
    chk("R10 dataOut low in clear", {47'h0, dOut}, 48'h0);
    hClr = 1'b1; waitClk(4);

    waitClk(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule